// File: doc/BRIEF.md
# Port Change Interrupt Generator

This block watches a 16-bit general-purpose port, organised as two 8-bit halves, and drives an active-low interrupt line. Each half keeps its own baseline copy of the pin levels. Any pin set up as an input whose synchronized level differs from its baseline bit marks that half as pending. The interrupt line is pulled low while either half is pending.

The serial slave front end sends two kinds of single-cycle event pulses. One kind says that a read of one port half has reached its acknowledge slot. The other says that a bus stop condition was seen. A read event clears only the half that was read. A stop event clears both halves. Each clear also loads the cleared baseline with the current synchronized pins, so later changes are judged against that new reference. The line is modelled as an output-enable (high means the line is pulled low) and also as an active-low copy.

Top module: `pcint_gen`

## Requirements
- R1: A level change on a pin whose direction bit is 1 (1 = input) sets `int_oe` high. The change is applied to `pin_raw` before clock edge k, and `int_oe` is high after edge k+2 (two synchronizer stages plus the pending register). It is not yet high after edge k+1.
- R2: A pin whose direction bit is 0 (output) never raises `int_oe`, whatever its level does.
- R3: When an input pin returns to its baseline level, the interrupt from that pin is withdrawn with the same three-edge latency as R1.
- R4: A pulse on `rd_ack[h]` clears half h on that edge. Half 0 is bits 7:0 and half 1 is bits 15:8. The same edge loads the baseline of half h with the current synchronized pins, so the half stays clear while those pins hold.
- R5: A read of one half never clears a change pending in the other half.
- R6: A pulse on `stop_evt` clears both halves on that edge and reloads both baselines.
- R7: Switching a pin from output to input while its synchronized level differs from its baseline sets `int_oe` after the next edge. The direction input is not synchronized.
- R8: While no read or stop pulse arrives, pending state persists. Bus traffic for other devices produces no pulse and so has no effect.
- R9: After a clear, a new change on an input pin raises the interrupt again.
- R10: Synchronous reset clears the synchronizers, the baselines and the pending state. `int_n` is always the inverse of `int_oe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_raw | input | 16 | Asynchronous pin levels |
| dir_in | input | 16 | Per-pin direction, 1 = input, 0 = output |
| rd_ack | input | 2 | Read-acknowledge pulse per half (bit 0 = pins 7:0) |
| stop_evt | input | 1 | Bus stop condition pulse |
| int_oe | output | 1 | Interrupt pull-down enable, high = line low |
| int_n | output | 1 | Active-low interrupt level |

## Verification
Each result has a fixed due time. A pin change is due on `int_oe` after the third rising edge. A direction change and a read or stop pulse both act on the first edge. The bench drives inputs on falling edges and samples on falling edges, and every explicit check waits exactly that many edges. One explicit check looks one edge early to confirm that R1 is not seen too soon. A behavioural model advances on each rising edge and is compared with both outputs on every falling edge, through directed and random traffic.

// File: rtl/pcint_pkg.sv
package pcint_pkg;
   localparam int PCINT_HALF_W_DEF  = 8;
   localparam int PCINT_HALVES_DEF  = 2;
   localparam int PCINT_SYNC_DEF    = 2;
   localparam int PCINT_SYNC_MIN    = 2;
endpackage

// File: rtl/pcint_sync.sv
module pcint_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   import pcint_pkg::*;

   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < PCINT_SYNC_MIN) begin : g_bad_stages
         $error("pcint_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("pcint_sync: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
      end else begin
         chain_q[0] <= d;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign q = chain_q[LAST];
endmodule

// File: rtl/pcint_half.sv
module pcint_half #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] pin_s,
   input  logic [W-1:0] dir,
   input  logic         clr,
   output logic         pend
);
   generate
      if (W < 1) begin : g_bad_w
         $error("pcint_half: W must be positive");
      end
   endgenerate

   logic [W-1:0] base_q;
   logic [W-1:0] diff;
   logic         pend_q;

   assign diff = dir & (pin_s ^ base_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         base_q <= '0;
         pend_q <= 1'b0;
      end else if (clr) begin
         base_q <= pin_s;
         pend_q <= 1'b0;
      end else begin
         pend_q <= |diff;
      end
   end

   assign pend = pend_q;

   // R4
   clear_drop_chk: assert property (@(posedge clk) disable iff (rst)
      clr |=> !pend_q);

   // R4
   baseline_reload_chk: assert property (@(posedge clk) disable iff (rst)
      clr |=> (base_q == $past(pin_s)));

   // R2
   output_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (dir == '0) |=> !pend_q);

   // R8
   pending_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (pend_q && !clr && (|diff)) |=> pend_q);
endmodule

// File: rtl/pcint_gen.sv
module pcint_gen #(
   parameter int HALF_W      = pcint_pkg::PCINT_HALF_W_DEF,
   parameter int HALVES      = pcint_pkg::PCINT_HALVES_DEF,
   parameter int SYNC_STAGES = pcint_pkg::PCINT_SYNC_DEF
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [HALF_W*HALVES-1:0]  pin_raw,
   input  logic [HALF_W*HALVES-1:0]  dir_in,
   input  logic [HALVES-1:0]         rd_ack,
   input  logic                      stop_evt,
   output logic                      int_oe,
   output logic                      int_n
);
   localparam int PORT_W = HALF_W * HALVES;

   generate
      if (HALVES < 1) begin : g_bad_halves
         $error("pcint_gen: HALVES must be positive");
      end
   endgenerate

   logic [PORT_W-1:0] pin_s;
   logic [HALVES-1:0] clr_vec;
   logic [HALVES-1:0] pend_vec;

   pcint_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) i_sync (
      .clk (clk),
      .rst (rst),
      .d   (pin_raw),
      .q   (pin_s)
   );

   generate
      for (genvar h = 0; h < HALVES; h++) begin : g_half
         assign clr_vec[h] = rd_ack[h] | stop_evt;

         pcint_half #(.W(HALF_W)) i_half (
            .clk   (clk),
            .rst   (rst),
            .pin_s (pin_s[h*HALF_W +: HALF_W]),
            .dir   (dir_in[h*HALF_W +: HALF_W]),
            .clr   (clr_vec[h]),
            .pend  (pend_vec[h])
         );
      end
   endgenerate

   assign int_oe = |pend_vec;
   assign int_n  = ~int_oe;

   // R6
   stop_clears_chk: assert property (@(posedge clk) disable iff (rst)
      stop_evt |=> !int_oe);

   // R10
   reset_quiet_chk: assert property (@(posedge clk)
      rst |=> !int_oe);
endmodule

// File: tb/test_pcint_gen.sv
module test_pcint_gen;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] pin_raw = '0;
   logic [15:0] dir_in = 16'hFFFF;
   logic [1:0]  rd_ack = '0;
   logic        stop_evt = 1'b0;
   logic        int_oe;
   logic        int_n;

   int n_chk = 0;
   int n_err = 0;

   pcint_gen i_pcint_gen (
      .clk      (clk),
      .rst      (rst),
      .pin_raw  (pin_raw),
      .dir_in   (dir_in),
      .rd_ack   (rd_ack),
      .stop_evt (stop_evt),
      .int_oe   (int_oe),
      .int_n    (int_n)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference: pin history two edges deep, baselines, pending
   int hist1 = 0, hist2 = 0;
   int base [2] = '{0, 0};
   bit mpend [2] = '{0, 0};

   always @(posedge clk) begin
      if (rst) begin
         hist1 = 0; hist2 = 0;
         for (int h = 0; h < 2; h++) begin base[h] = 0; mpend[h] = 0; end
      end else begin
         for (int h = 0; h < 2; h++) begin
            int seen, dirs;
            seen = (hist2 >> (8*h)) & 8'hFF;
            dirs = (dir_in >> (8*h)) & 8'hFF;
            if (rd_ack[h] || stop_evt) begin
               base[h] = seen;
               mpend[h] = 0;
            end else begin
               mpend[h] = ((dirs & (seen ^ base[h])) != 0);
            end
         end
         hist2 = hist1;
         hist1 = int'(pin_raw);
      end
   end

   task automatic chk(string req, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!rst) begin
         chk("R1 model int_oe", int_oe, mpend[0] | mpend[1]);
         chk("R10 model int_n", int_n, ~(mpend[0] | mpend[1]));
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      step(3);
      chk("R10 reset int_oe", int_oe, 1'b0);
      chk("R10 reset int_n", int_n, 1'b1);
      rst = 1'b0;
      step(2);

      // R1 latency
      pin_raw[3] = 1'b1;
      step(2);
      chk("R1 not early", int_oe, 1'b0);
      step(1);
      chk("R1 rise", int_oe, 1'b1);

      // R3 return to baseline
      pin_raw[3] = 1'b0;
      step(3);
      chk("R3 withdraw", int_oe, 1'b0);

      // R2 output pin
      dir_in[10] = 1'b0;
      pin_raw[10] = 1'b1;
      step(5);
      chk("R2 output quiet", int_oe, 1'b0);

      // R7 output to input with mismatch
      dir_in[10] = 1'b1;
      step(1);
      chk("R7 false irq", int_oe, 1'b1);

      // R5 per-half read isolation
      rd_ack = 2'b01; step(1); rd_ack = 2'b00;
      chk("R5 read0 keeps half1", int_oe, 1'b1);
      pin_raw[1] = 1'b1;
      step(3);
      rd_ack = 2'b10; step(1); rd_ack = 2'b00;
      chk("R5 read1 keeps half0", int_oe, 1'b1);
      rd_ack = 2'b01; step(1); rd_ack = 2'b00;
      chk("R4 read clears", int_oe, 1'b0);
      step(3);
      chk("R4 baseline reloaded", int_oe, 1'b0);

      // R8 persistence without events
      pin_raw[12] = 1'b1;
      step(3);
      chk("R8 raised", int_oe, 1'b1);
      step(10);
      chk("R8 persists", int_oe, 1'b1);

      // R6 stop clears
      stop_evt = 1'b1; step(1); stop_evt = 1'b0;
      chk("R6 stop clears", int_oe, 1'b0);
      step(3);
      chk("R6 stays clear", int_oe, 1'b0);

      // R9 new change after clear
      pin_raw[12] = 1'b0;
      step(3);
      chk("R9 re-raise", int_oe, 1'b1);
      stop_evt = 1'b1; step(1); stop_evt = 1'b0;

      // random traffic, checked by the model
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         if ($urandom % 4 == 0) pin_raw[$urandom % 16] ^= 1'b1;
         if ($urandom % 25 == 0) dir_in[$urandom % 16] ^= 1'b1;
         rd_ack = ($urandom % 7 == 0) ? 2'($urandom) : 2'b00;
         stop_evt = ($urandom % 15 == 0);
      end
      rd_ack = '0;
      stop_evt = 1'b0;
      step(4);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule